// File: doc/BRIEF.md
# Read-Sequence Command Decoder

This block sits beside an asynchronous-style SRAM host port and watches its read traffic after the port pins have been brought into the local clock. A host issues a command with no dedicated command pins. It reads a fixed chain of six addresses in a row. The first five addresses are the same for every command, and the sixth address picks one of four actions: persist the array contents, reload the array from persistent storage, turn automatic power-fail persisting off, or turn it back on.

When the chain completes, the decoder raises exactly one of four command outputs for a single clock cycle. It then holds a processing lockout for a programmable number of cycles, and no further step is accepted during that time. The persist and reload commands also raise a bus-float flag for a longer programmable window, which tells the data path to hold its drivers in high impedance while the operation runs.

A read marks a step at one of two edges: the chip-enable rising edge, or an output-enable rising edge while chip-enable stays low. Output-enable being low is not needed for a chip-enable step. Any write resets the chain. A read of a wrong address also resets it. The current chain position is brought out so that abort and restart behaviour can be observed.

Top module: `seq_cmd_decoder`

## Requirements
- R1: After reset, seq_pos is 0, all four command outputs are 0, and lockout and io_off are 0.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, move seq_pos through 1, 2, 3, 4 and 5.
- R3: At seq_pos 5, a read of 0x8FC0 pulses cmd_store, 0x4C63 pulses cmd_recall, 0x8B45 pulses cmd_as_off and 0x4B46 pulses cmd_as_on. The pulse lasts exactly one cycle, and seq_pos returns to 0.
- R4: At seq_pos 5, a read of any address other than the four command addresses fires no command.
- R5: A write access is one where write-enable is low at the end of the access. Any write access that is taken as a step returns seq_pos to 0.
- R6: A read whose address is not the next expected one returns seq_pos to 0. If that address is 0x4E38, seq_pos becomes 1 instead.
- R7: An output-enable rising edge while chip-enable is low counts as a step. A chip-enable rising edge counts as a step even when output-enable stays high throughout.
- R8: An access that ends while busy_n is low leaves seq_pos unchanged.
- R9: lockout is high for exactly SS_CYCLES cycles, starting in the same cycle as the command pulse. Accesses that end during lockout leave seq_pos unchanged.
- R10: io_off is high for exactly OP_CYCLES cycles after cmd_store or cmd_recall, and stays low for cmd_as_off and cmd_as_on.
- R11: At most one command output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| oe_n | input | 1 | Host output enable, active low, asynchronous |
| we_n | input | 1 | Host write enable, active low, asynchronous |
| busy_n | input | 1 | Busy line, low while another operation holds the port |
| addr_lo | input | 16 | Low 16 host address bits |
| cmd_store | output | 1 | One-cycle persist command |
| cmd_recall | output | 1 | One-cycle reload command |
| cmd_as_off | output | 1 | One-cycle automatic-persist disable command |
| cmd_as_on | output | 1 | One-cycle automatic-persist enable command |
| lockout | output | 1 | Processing window after any command |
| io_off | output | 1 | Data bus must float during persist or reload |
| seq_pos | output | 3 | Count of chain steps matched so far |

## Verification
On every cycle, the assertions check these properties: one-hot command outputs, single-cycle pulses, lockout present alongside each pulse, the chain position bound, position hold while busy is low, the reset of the position on a write, and the start of each hold window. Some behaviour only the bench scenarios can show: the exact address values that advance, restart or abort the chain; the mapping of each sixth address to its command; the two kinds of step edge; and the exact lengths of the lockout and bus-float windows. The bench covers these by sweeping all four commands and by aborting at every chain position with both a foreign address and the chain's first address.

// File: rtl/seqdec_pkg.sv
package seqdec_pkg;

  localparam int PREFIX_LEN = 5;
  localparam int POS_W      = $clog2(PREFIX_LEN + 1);
  localparam int NUM_CMDS   = 4;

  typedef enum logic [1:0] {
    CMD_STORE  = 2'd0,
    CMD_RECALL = 2'd1,
    CMD_AS_OFF = 2'd2,
    CMD_AS_ON  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic hit;
    cmd_e kind;
  } final_lookup_t;

  // expected address for chain step idx (0-based)
  function automatic logic [15:0] prefix_addr(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  function automatic final_lookup_t final_lookup(input logic [15:0] a);
    final_lookup_t r;
    r.hit  = 1'b1;
    r.kind = CMD_STORE;
    case (a)
      16'h8FC0: r.kind = CMD_STORE;
      16'h4C63: r.kind = CMD_RECALL;
      16'h8B45: r.kind = CMD_AS_OFF;
      16'h4B46: r.kind = CMD_AS_ON;
      default:  r.hit  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/access_sampler.sv
module access_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        busy_n,
  input  logic [15:0] addr_lo,
  output logic        ev_read,
  output logic        ev_write,
  output logic        busy_ok,
  output logic [15:0] addr_s
);

  localparam int BW = 20;
  localparam logic [BW-1:0] IDLE = {4'hF, 16'h0000};

  logic [BW-1:0] raw;
  logic [BW-1:0] stage [SYNC_STAGES];
  logic          ce_s, oe_s, we_s;
  logic          ce_p, oe_p, we_p;
  logic          edge_any;

  assign raw = {busy_n, we_n, oe_n, ce_n, addr_lo};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= IDLE;
        else     stage[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= IDLE;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign busy_ok = stage[SYNC_STAGES-1][19];
  assign we_s    = stage[SYNC_STAGES-1][18];
  assign oe_s    = stage[SYNC_STAGES-1][17];
  assign ce_s    = stage[SYNC_STAGES-1][16];
  assign addr_s  = stage[SYNC_STAGES-1][15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_p <= 1'b1;
      oe_p <= 1'b1;
      we_p <= 1'b1;
    end else begin
      ce_p <= ce_s;
      oe_p <= oe_s;
      we_p <= we_s;
    end
  end

  // end of access: chip-enable rises, or output-enable rises while selected
  assign edge_any = (ce_s & ~ce_p) | (oe_s & ~oe_p & ~ce_s);
  assign ev_write = edge_any & (~we_s | ~we_p);
  assign ev_read  = edge_any & we_s & we_p;

endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
  import seqdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_read,
  input  logic                ev_write,
  input  logic                busy_ok,
  input  logic                locked,
  input  logic [15:0]         addr_s,
  output logic                fire,
  output cmd_e                fire_kind,
  output logic [NUM_CMDS-1:0] cmd_q,
  output logic [POS_W-1:0]    pos_q
);

  localparam logic [POS_W-1:0] LAST = POS_W'(PREFIX_LEN);

  logic            take;
  logic [POS_W-1:0] pos_d;
  logic            restart_hit;
  final_lookup_t   lk;

  assign take        = (ev_read | ev_write) & busy_ok & ~locked;
  assign restart_hit = (addr_s == prefix_addr(0));
  assign lk          = final_lookup(addr_s);

  always_comb begin
    pos_d     = pos_q;
    fire      = 1'b0;
    fire_kind = lk.kind;
    if (take) begin
      if (ev_write) begin
        pos_d = '0;
      end else if (pos_q == LAST) begin
        if (lk.hit) begin
          fire  = 1'b1;
          pos_d = '0;
        end else begin
          pos_d = restart_hit ? POS_W'(1) : '0;
        end
      end else if (addr_s == prefix_addr(int'(pos_q))) begin
        pos_d = pos_q + POS_W'(1);
      end else begin
        pos_d = restart_hit ? POS_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      cmd_q <= '0;
    end else begin
      pos_q <= pos_d;
      cmd_q <= '0;
      if (fire) cmd_q[fire_kind] <= 1'b1;
    end
  end

  a_r2_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_ok |=> $stable(pos_q));

  a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
    (take && ev_write) |=> (pos_q == '0));

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end else begin
      active <= 1'b0;
    end
  end

  a_r9_hold_starts: assert property (@(posedge clk) disable iff (rst)
    start |=> active);

  a_r10_idle_count: assert property (@(posedge clk) disable iff (rst)
    !active |-> (cnt == '0));

endmodule

// File: rtl/seq_cmd_decoder.sv
module seq_cmd_decoder
  import seqdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SS_CYCLES   = 1000,
  parameter int OP_CYCLES   = 4000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        busy_n,
  input  logic [15:0] addr_lo,
  output logic        cmd_store,
  output logic        cmd_recall,
  output logic        cmd_as_off,
  output logic        cmd_as_on,
  output logic        lockout,
  output logic        io_off,
  output logic [2:0]  seq_pos
);

  logic                ev_read, ev_write, busy_ok;
  logic [15:0]         addr_s;
  logic                fire;
  cmd_e                fire_kind;
  logic [NUM_CMDS-1:0] cmd_q;
  logic [POS_W-1:0]    pos_q;
  logic                io_start;

  access_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy_n(busy_n), .addr_lo(addr_lo),
    .ev_read(ev_read), .ev_write(ev_write), .busy_ok(busy_ok), .addr_s(addr_s)
  );

  seq_tracker u_tracker (
    .clk(clk), .rst(rst),
    .ev_read(ev_read), .ev_write(ev_write), .busy_ok(busy_ok),
    .locked(lockout), .addr_s(addr_s),
    .fire(fire), .fire_kind(fire_kind), .cmd_q(cmd_q), .pos_q(pos_q)
  );

  hold_timer #(.CYCLES(SS_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .start(fire), .active(lockout)
  );

  assign io_start = fire & ((fire_kind == CMD_STORE) | (fire_kind == CMD_RECALL));

  hold_timer #(.CYCLES(OP_CYCLES)) u_iohold (
    .clk(clk), .rst(rst), .start(io_start), .active(io_off)
  );

  assign cmd_store  = cmd_q[CMD_STORE];
  assign cmd_recall = cmd_q[CMD_RECALL];
  assign cmd_as_off = cmd_q[CMD_AS_OFF];
  assign cmd_as_on  = cmd_q[CMD_AS_ON];
  assign seq_pos    = 3'(pos_q);

  a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_store, cmd_recall, cmd_as_off, cmd_as_on}));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (cmd_store | cmd_recall | cmd_as_off | cmd_as_on)
      |=> !(cmd_store | cmd_recall | cmd_as_off | cmd_as_on));

  a_r9_lock_with_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_store | cmd_recall | cmd_as_off | cmd_as_on) |-> lockout);

endmodule

// File: tb/test_seq_cmd_decoder.sv
module test_seq_cmd_decoder;

  localparam int SS = 20;
  localparam int OP = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy_n = 1'b1;
  logic [15:0] addr_lo = 16'h0;
  logic        cmd_store, cmd_recall, cmd_as_off, cmd_as_on, lockout, io_off;
  logic [2:0]  seq_pos;

  int checks = 0;
  int errors = 0;
  int n_st = 0, n_rc = 0, n_off = 0, n_on = 0, n_lock = 0, n_io = 0;

  always #4 clk = ~clk;

  seq_cmd_decoder #(.SYNC_STAGES(2), .SS_CYCLES(SS), .OP_CYCLES(OP)) i_seq_cmd_decoder (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy_n(busy_n),
    .addr_lo(addr_lo), .cmd_store(cmd_store), .cmd_recall(cmd_recall),
    .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on), .lockout(lockout),
    .io_off(io_off), .seq_pos(seq_pos)
  );

  always @(negedge clk) begin
    if (!rst) begin
      n_st   += int'(cmd_store);
      n_rc   += int'(cmd_recall);
      n_off  += int'(cmd_as_off);
      n_on   += int'(cmd_as_on);
      n_lock += int'(lockout);
      n_io   += int'(io_off);
    end
  end

  function automatic logic [15:0] step_addr(input int i);
    case (i)
      0: return 16'h4E38;
      1: return 16'hB1C7;
      2: return 16'h83E0;
      3: return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  function automatic logic [15:0] cmd_addr(input int k);
    case (k)
      0: return 16'h8FC0;
      1: return 16'h4C63;
      2: return 16'h8B45;
      default: return 16'h4B46;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_st = 0; n_rc = 0; n_off = 0; n_on = 0; n_lock = 0; n_io = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // chip-enable controlled read; oe_low selects whether output-enable drops
  task automatic rd(input logic [15:0] a, input bit oe_low);
    @(negedge clk);
    addr_lo = a; we_n = 1'b1; ce_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
    idle(3);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(4);
  endtask

  // output-enable controlled read, chip enable held low by caller
  task automatic oerd(input logic [15:0] a);
    @(negedge clk);
    addr_lo = a; oe_n = 1'b0;
    idle(3);
    oe_n = 1'b1;
    idle(4);
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk);
    addr_lo = a; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(4);
  endtask

  task automatic prefix_to(input int p);
    for (int i = 0; i < p; i++) rd(step_addr(i), 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 seq_pos", int'(seq_pos), 0);
    chk("R1 commands", int'({cmd_store, cmd_recall, cmd_as_off, cmd_as_on}), 0);
    chk("R1 lockout", int'(lockout), 0);
    chk("R1 io_off", int'(io_off), 0);

    // R2, R3, R9, R10: every command via chip-enable reads
    for (int k = 0; k < 4; k++) begin
      clear_counts();
      for (int i = 0; i < 5; i++) begin
        rd(step_addr(i), 1'b1);
        chk("R2 step position", int'(seq_pos), i + 1);
      end
      rd(cmd_addr(k), 1'b1);
      chk("R3 position after command", int'(seq_pos), 0);
      idle(OP + 10);
      chk("R3 store pulses",  n_st,  (k == 0) ? 1 : 0);
      chk("R3 recall pulses", n_rc,  (k == 1) ? 1 : 0);
      chk("R3 as_off pulses", n_off, (k == 2) ? 1 : 0);
      chk("R3 as_on pulses",  n_on,  (k == 3) ? 1 : 0);
      chk("R9 lockout length", n_lock, SS);
      chk("R10 io_off length", n_io, (k < 2) ? OP : 0);
    end

    // R4: wrong sixth address fires nothing
    clear_counts();
    prefix_to(5);
    rd(16'h8FC1, 1'b1);
    idle(5);
    chk("R4 no command", n_st + n_rc + n_off + n_on, 0);
    chk("R4 position", int'(seq_pos), 0);

    // R5: write aborts
    prefix_to(3);
    chk("R5 before write", int'(seq_pos), 3);
    wr(step_addr(3));
    chk("R5 write aborts", int'(seq_pos), 0);

    // R6: abort sweep at every position, foreign and restart address
    for (int p = 1; p <= 5; p++) begin
      prefix_to(p);
      rd(16'h1234, 1'b1);
      chk("R6 foreign abort", int'(seq_pos), 0);
      prefix_to(p);
      rd(16'h4E38, 1'b1);
      chk("R6 restart at step two", int'(seq_pos), 1);
      rd(16'hB1C7, 1'b1);
      chk("R6 continue after restart", int'(seq_pos), 2);
      rd(16'h0000, 1'b1);
      chk("R6 clear", int'(seq_pos), 0);
    end

    // R7: output-enable controlled chain with chip enable held low
    clear_counts();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    idle(3);
    for (int i = 0; i < 5; i++) begin
      oerd(step_addr(i));
      chk("R7 oe step position", int'(seq_pos), i + 1);
    end
    oerd(cmd_addr(0));
    idle(2);
    ce_n = 1'b1;   // ends inside lockout, must be ignored (R9)
    idle(OP + 10);
    chk("R7 oe store pulse", n_st, 1);
    chk("R9 ignored edge in lockout", int'(seq_pos), 0);

    // R7: chip-enable reads with output enable never low
    clear_counts();
    for (int i = 0; i < 5; i++) rd(step_addr(i), 1'b0);
    chk("R7 ce step with oe high", int'(seq_pos), 5);
    rd(cmd_addr(1), 1'b0);
    idle(3);
    chk("R7 recall pulse", n_rc, 1);
    // R9: a valid first step inside lockout is ignored
    rd(16'h4E38, 1'b1);
    chk("R9 step during lockout", int'(seq_pos), 0);
    idle(OP + 10);

    // R8: busy low freezes the position
    prefix_to(2);
    @(negedge clk);
    busy_n = 1'b0;
    rd(step_addr(2), 1'b1);
    chk("R8 busy valid step", int'(seq_pos), 2);
    rd(16'h5555, 1'b1);
    chk("R8 busy foreign read", int'(seq_pos), 2);
    wr(16'h5555);
    chk("R8 busy write", int'(seq_pos), 2);
    busy_n = 1'b1;
    idle(3);
    rd(step_addr(2), 1'b1);
    chk("R8 resume after busy", int'(seq_pos), 3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule